// File: doc/BRIEF.md
# AXI Burst Traffic Generator

This block is a self-contained AXI test master. A single `start` pulse makes it write a fixed number of INCR bursts to consecutive address windows. It then reads the same windows back and compares every returned beat against the data it wrote. The block keeps only one transaction in flight at any time. The write bursts finish before the first read address is issued.

Each write beat carries a value built from the transaction number and the beat index, so the read phase can recompute the expected data without storing it. Two sticky flags report problems, one for the write phase and one for the read phase. A `done` flag reports that the last read burst has ended. A later `start` clears these flags and runs the whole sequence again.

Top module: `axi_burst_tgen`

## Requirements
- R1: While reset is low and right after it is released, AWVALID, WVALID, ARVALID, BREADY, RREADY, `done`, `err_write` and `err_read` are all 0.
- R2: After `start`, exactly NUM_TXN write bursts are issued. Burst n uses address BASE_ADDR + n·BURST_LEN·(DATA_W/8), AxLEN = BURST_LEN−1 (the count of beats minus one), AxSIZE = log2(DATA_W/8) and AxBURST = 2'b01 (INCR). The read bursts use the same addresses and fields.
- R3: Once AWVALID or ARVALID is raised, it stays high with a stable address until the cycle the slave accepts it. It is low from the next cycle on.
- R4: Each write burst has exactly BURST_LEN accepted W beats, and WLAST is high on the last beat only. WVALID, WDATA and WLAST hold while WREADY is low.
- R5: Beat b of transaction n carries WDATA = {8'hA5, n[7:0], b[15:0]} in the low 32 bits, and WSTRB is all ones.
- R6: BREADY is high from the start of a write burst until its response is accepted. RREADY is high from the start of a read burst until the beat with RLAST is accepted. Neither ever makes a valid slave wait.
- R7: Only one burst is active at a time. The next AW follows the previous B handshake, and no AR is issued before all NUM_TXN write responses are accepted.
- R8: Every accepted read beat is compared with the R5 pattern for its transaction and beat index. Any mismatch sets `err_read`.
- R9: An accepted B with BRESP[1]=1 (SLVERR 2'b10, DECERR 2'b11) sets `err_write`. An accepted R beat with RRESP[1]=1 sets `err_read`. A response of 2'b01 sets nothing.
- R10: `done` rises after the RLAST beat of the last read burst and stays high until the next accepted `start`. That `start` clears `done`, `err_write` and `err_read`.
- R11: A `start` pulse is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (accepted only when idle or done) |
| done | output | 1 | Run finished |
| err_write | output | 1 | Sticky write response error |
| err_read | output | 1 | Sticky read response or data mismatch |
| awaddr | output | ADDR_W | Write burst address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Bytes per beat, log2 |
| awburst | output | 2 | Burst type (INCR) |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Final write beat |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read burst address |
| arlen | output | 8 | Beats minus one |
| arsize | output | 3 | Bytes per beat, log2 |
| arburst | output | 2 | Burst type (INCR) |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response |
| rlast | input | 1 | Final read beat |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
Some rules can be checked on every clock cycle. These are the holding of address and write beats under back-pressure, WLAST on the final beat index only, BREADY and RREADY held high during their bursts, the write and read phases never overlapping, and a quiet bus once `done` is set. Other points need the bench's own slave model and its scenarios. These are the address sequence, the data pattern that reaches memory, the response-bit decoding, a corrupted read beat, a mid-run `start` that must be ignored, and the clearing of the error flags on restart.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DONE  = 2'd3
  } tgen_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;

  // Test word for one beat: marker byte, transaction byte, beat index
  function automatic logic [31:0] beat_pattern(int txn, int beat);
    return {8'hA5, 8'(txn), 16'(beat)};
  endfunction

  // AxSIZE code for a beat of the given byte count
  function automatic logic [2:0] size_code(int bytes);
    return 3'($clog2(bytes));
  endfunction

  // Start address of transaction n
  function automatic logic [63:0] txn_addr(logic [63:0] base, int txn, int burst_bytes);
    return base + 64'(txn) * 64'(burst_bytes);
  endfunction

  // Response bit 1 marks slave or decode error
  function automatic logic resp_is_error(logic [1:0] resp);
    return resp[1];
  endfunction

endpackage

// File: rtl/tgen_wr_chan.sv
module tgen_wr_chan #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int TXN_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [TXN_W-1:0]    txn,
  input  logic [ADDR_W-1:0]   addr_in,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready,
  output logic                burst_end,
  output logic                resp_err
);
  import tgen_pkg::*;

  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST_LEN - 1);
  localparam logic [BEAT_W-1:0] PEN_IDX  = BEAT_W'(BURST_LEN - 2);

  logic [BEAT_W-1:0] wbeat;
  logic aw_hs, w_hs;

  assign aw_hs     = awvalid && awready;
  assign w_hs      = wvalid && wready;
  assign burst_end = bvalid && bready;
  assign resp_err  = burst_end && resp_is_error(bresp);

  assign awlen   = 8'(BURST_LEN - 1);
  assign awsize  = size_code(DATA_W / 8);
  assign awburst = BURST_INCR;
  assign wstrb   = '1;
  assign wdata   = DATA_W'(beat_pattern(int'(txn), int'(wbeat)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awvalid <= 1'b0;
      awaddr  <= '0;
      wvalid  <= 1'b0;
      wlast   <= 1'b0;
      wbeat   <= '0;
      bready  <= 1'b0;
    end else if (go) begin
      awvalid <= 1'b1;
      awaddr  <= addr_in;
      wvalid  <= 1'b1;
      wbeat   <= '0;
      wlast   <= (BURST_LEN == 1);
      bready  <= 1'b1;
    end else begin
      if (aw_hs) awvalid <= 1'b0;
      if (w_hs) begin
        if (wlast) begin
          wvalid <= 1'b0;
          wlast  <= 1'b0;
        end else begin
          wbeat <= wbeat + 1'b1;
          wlast <= (wbeat == PEN_IDX);
        end
      end
      if (burst_end) bready <= 1'b0;
    end
  end

  assert_aw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  assert_w_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));
  assert_wlast_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && wlast |-> wbeat == LAST_IDX);
  assert_bready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid || wvalid) |-> bready);

endmodule

// File: rtl/tgen_rd_chan.sv
module tgen_rd_chan #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int TXN_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [TXN_W-1:0]  txn,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  input  logic              rvalid,
  output logic              rready,
  output logic              burst_end,
  output logic              beat_err
);
  import tgen_pkg::*;

  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic [BEAT_W-1:0] rbeat;
  logic [DATA_W-1:0] expected;
  logic ar_hs, r_hs, data_mismatch, resp_bad;

  assign ar_hs         = arvalid && arready;
  assign r_hs          = rvalid && rready;
  assign expected      = DATA_W'(beat_pattern(int'(txn), int'(rbeat)));
  assign data_mismatch = r_hs && (rdata != expected);
  assign resp_bad      = r_hs && resp_is_error(rresp);
  assign beat_err      = data_mismatch || resp_bad;
  assign burst_end     = r_hs && rlast;

  assign arlen   = 8'(BURST_LEN - 1);
  assign arsize  = size_code(DATA_W / 8);
  assign arburst = BURST_INCR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arvalid <= 1'b0;
      araddr  <= '0;
      rready  <= 1'b0;
      rbeat   <= '0;
    end else if (go) begin
      arvalid <= 1'b1;
      araddr  <= addr_in;
      rready  <= 1'b1;
      rbeat   <= '0;
    end else begin
      if (ar_hs) arvalid <= 1'b0;
      if (r_hs) begin
        rbeat <= rbeat + 1'b1;
        if (rlast) rready <= 1'b0;
      end
    end
  end

  assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));
  assert_rready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> rready);

endmodule

// File: rtl/axi_burst_tgen.sv
module axi_burst_tgen #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          BURST_LEN = 4,
  parameter int          NUM_TXN   = 3,
  parameter logic [63:0] BASE_ADDR = 64'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                done,
  output logic                err_write,
  output logic                err_read,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready,
  output logic [ADDR_W-1:0]   araddr,
  output logic [7:0]          arlen,
  output logic [2:0]          arsize,
  output logic [1:0]          arburst,
  output logic                arvalid,
  input  logic                arready,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          rresp,
  input  logic                rlast,
  input  logic                rvalid,
  output logic                rready
);
  import tgen_pkg::*;

  localparam int TXN_W       = (NUM_TXN > 1) ? $clog2(NUM_TXN) : 1;
  localparam int BURST_BYTES = BURST_LEN * (DATA_W / 8);
  localparam logic [TXN_W-1:0] LAST_TXN = TXN_W'(NUM_TXN - 1);

  tgen_state_e       state;
  logic [TXN_W-1:0]  txn;
  logic [ADDR_W-1:0] cur_addr;
  logic go_wr, go_rd, launch;
  logic wr_end, wr_err, rd_end, rd_err;
  logic wr_busy, rd_busy;

  assign launch   = start && (state == ST_IDLE || state == ST_DONE);
  assign cur_addr = ADDR_W'(txn_addr(BASE_ADDR, int'(txn), BURST_BYTES));
  assign wr_busy  = awvalid || wvalid || bready;
  assign rd_busy  = arvalid || rready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      txn       <= '0;
      go_wr     <= 1'b0;
      go_rd     <= 1'b0;
      done      <= 1'b0;
      err_write <= 1'b0;
      err_read  <= 1'b0;
    end else begin
      go_wr <= 1'b0;
      go_rd <= 1'b0;
      if (wr_err) err_write <= 1'b1;
      if (rd_err) err_read  <= 1'b1;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            state     <= ST_WRITE;
            txn       <= '0;
            go_wr     <= 1'b1;
            done      <= 1'b0;
            err_write <= 1'b0;
            err_read  <= 1'b0;
          end
        end
        ST_WRITE: begin
          if (wr_end) begin
            if (txn == LAST_TXN) begin
              state <= ST_READ;
              txn   <= '0;
              go_rd <= 1'b1;
            end else begin
              txn   <= txn + 1'b1;
              go_wr <= 1'b1;
            end
          end
        end
        ST_READ: begin
          if (rd_end) begin
            if (txn == LAST_TXN) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end else begin
              txn   <= txn + 1'b1;
              go_rd <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  tgen_wr_chan #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .TXN_W(TXN_W)
  ) wr_chan_i (
    .clk(clk), .rst_n(rst_n), .go(go_wr), .txn(txn), .addr_in(cur_addr),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .burst_end(wr_end), .resp_err(wr_err)
  );

  tgen_rd_chan #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .TXN_W(TXN_W)
  ) rd_chan_i (
    .clk(clk), .rst_n(rst_n), .go(go_rd), .txn(txn), .addr_in(cur_addr),
    .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
    .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready),
    .burst_end(rd_end), .beat_err(rd_err)
  );

  assert_phases_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_busy && rd_busy));
  assert_ar_after_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> state == ST_READ);
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_busy && !rd_busy);
  assert_txn_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(txn) < NUM_TXN);
  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

endmodule

// File: tb/axi_burst_tgen_tb_top.sv
module axi_burst_tgen_tb_top;

  localparam int LEN  = 4;
  localparam int NUM  = 3;
  localparam int DW   = 32;
  localparam int AW   = 32;
  localparam int BASE = 32'h100;
  localparam int BBYTES = LEN * DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic done, err_write, err_read;
  logic [AW-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst, bresp, rresp;
  logic awvalid, awready, wlast, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rlast, rvalid, rready;
  logic [DW-1:0] wdata, rdata;
  logic [DW/8-1:0] wstrb;

  axi_burst_tgen #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(LEN), .NUM_TXN(NUM),
                   .BASE_ADDR(64'(BASE))) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .err_write(err_write), .err_read(err_read),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
    .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
  );

  // scenario knobs
  logic bp = 1'b0;
  logic clr = 1'b0;
  logic [1:0] bresp_cfg = 2'b00;
  logic [1:0] rresp_cfg = 2'b00;
  int bresp_txn = -1, rresp_txn = -1, corrupt_txn = -1;

  // slave state
  logic [31:0] mem [0:63];
  int cyc = 0;
  logic aw_got = 0, w_done = 0, ar_got = 0, bvalid_r = 0;
  logic [1:0] bresp_r = 0;
  int aw_idx = 0, ar_idx = 0, wcnt = 0, rcnt = 0;
  logic p_awv = 0, p_awr = 0, p_arv = 0, p_arr = 0;
  logic [AW-1:0] p_awaddr = 0, p_araddr = 0;

  // monitor counters
  int aw_cnt = 0, w_cnt = 0, b_cnt = 0, ar_cnt = 0, r_cnt = 0;
  int addr_bad = 0, fmt_bad = 0, wlast_bad = 0, data_bad = 0, strb_bad = 0;
  int order_bad = 0, overlap_bad = 0, bwait_bad = 0, rwait_bad = 0, hold_bad = 0;

  function automatic logic [31:0] pat(int t, int b);
    return {8'hA5, 8'(t), 16'(b)};
  endfunction

  assign awready = !aw_got && (!bp || cyc[0]);
  assign wready  = aw_got && !w_done && (!bp || cyc[1]);
  assign bvalid  = bvalid_r;
  assign bresp   = bresp_r;
  assign arready = !ar_got && (!bp || cyc[0]);
  assign rvalid  = ar_got && (!bp || cyc[1]);
  assign rlast   = (rcnt == LEN - 1);
  assign rdata   = mem[(ar_idx + rcnt) & 63] ^
                   (((corrupt_txn == ar_cnt - 1) && rcnt == 1) ? 32'h0000_0100 : 32'h0);
  assign rresp   = (rresp_txn == ar_cnt - 1) ? rresp_cfg : 2'b00;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    p_awv <= awvalid; p_awr <= awready; p_awaddr <= awaddr;
    p_arv <= arvalid; p_arr <= arready; p_araddr <= araddr;
    if (!rst_n) begin
      aw_got <= 0; w_done <= 0; ar_got <= 0; bvalid_r <= 0; wcnt <= 0; rcnt <= 0;
    end else begin
      if (clr) begin
        aw_cnt <= 0; w_cnt <= 0; b_cnt <= 0; ar_cnt <= 0; r_cnt <= 0;
        addr_bad <= 0; fmt_bad <= 0; wlast_bad <= 0; data_bad <= 0; strb_bad <= 0;
        order_bad <= 0; overlap_bad <= 0; bwait_bad <= 0; rwait_bad <= 0; hold_bad <= 0;
      end else begin
        if (p_awv && !p_awr && (!awvalid || awaddr != p_awaddr)) hold_bad <= hold_bad + 1;
        if (p_arv && !p_arr && (!arvalid || araddr != p_araddr)) hold_bad <= hold_bad + 1;
        if (awvalid && awready) begin
          if (awaddr != AW'(BASE + aw_cnt * BBYTES)) addr_bad <= addr_bad + 1;
          if (awlen != 8'(LEN-1) || awsize != 3'd2 || awburst != 2'b01) fmt_bad <= fmt_bad + 1;
          if (aw_cnt != b_cnt) overlap_bad <= overlap_bad + 1;
          aw_cnt <= aw_cnt + 1;
        end
        if (wvalid && wready) begin
          if (wdata != pat(aw_cnt - 1, wcnt)) data_bad <= data_bad + 1;
          if (wstrb != '1) strb_bad <= strb_bad + 1;
          if (wlast != (wcnt == LEN - 1)) wlast_bad <= wlast_bad + 1;
          w_cnt <= w_cnt + 1;
        end
        if (bvalid_r && bready) b_cnt <= b_cnt + 1;
        if (bvalid_r && !bready) bwait_bad <= bwait_bad + 1;
        if (arvalid && arready) begin
          if (araddr != AW'(BASE + ar_cnt * BBYTES)) addr_bad <= addr_bad + 1;
          if (arlen != 8'(LEN-1) || arsize != 3'd2 || arburst != 2'b01) fmt_bad <= fmt_bad + 1;
          if (b_cnt != NUM) order_bad <= order_bad + 1;
          ar_cnt <= ar_cnt + 1;
        end
        if (rvalid && rready) r_cnt <= r_cnt + 1;
        if (rvalid && !rready) rwait_bad <= rwait_bad + 1;
      end
      // slave behaviour
      if (awvalid && awready) begin
        aw_got <= 1; aw_idx <= int'(awaddr >> 2) & 63;
      end
      if (wvalid && wready) begin
        mem[(aw_idx + wcnt) & 63] <= wdata;
        wcnt <= wcnt + 1;
        if (wlast) w_done <= 1;
      end
      if (aw_got && w_done && !bvalid_r) begin
        bvalid_r <= 1;
        bresp_r  <= (b_cnt == bresp_txn) ? bresp_cfg : 2'b00;
      end
      if (bvalid_r && bready) begin
        bvalid_r <= 0; aw_got <= 0; w_done <= 0; wcnt <= 0;
      end
      if (arvalid && arready) begin
        ar_got <= 1; ar_idx <= int'(araddr >> 2) & 63; rcnt <= 0;
      end
      if (rvalid && rready) begin
        rcnt <= rcnt + 1;
        if (rlast) begin ar_got <= 0; rcnt <= 0; end
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(logic bp_i, logic [1:0] bc, int bt, logic [1:0] rc, int rt, int ct);
    @(negedge clk);
    bp = bp_i; bresp_cfg = bc; bresp_txn = bt; rresp_cfg = rc; rresp_txn = rt;
    corrupt_txn = ct; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check({req, " run completes"}, int'(done), 1);
  endtask

  task automatic check_traffic(string tag);
    check({tag, " R2 write bursts"}, aw_cnt, NUM);
    check({tag, " R2 read bursts"}, ar_cnt, NUM);
    check({tag, " R2 addresses"}, addr_bad, 0);
    check({tag, " R2 len/size/burst"}, fmt_bad, 0);
    check({tag, " R3 valid/address hold"}, hold_bad, 0);
    check({tag, " R4 beat count"}, w_cnt, NUM * LEN);
    check({tag, " R4 wlast position"}, wlast_bad, 0);
    check({tag, " R5 write pattern"}, data_bad, 0);
    check({tag, " R5 strobes"}, strb_bad, 0);
    check({tag, " R6 bready never waits"}, bwait_bad, 0);
    check({tag, " R6 rready never waits"}, rwait_bad, 0);
    check({tag, " R7 read after writes"}, order_bad, 0);
    check({tag, " R7 one burst at a time"}, overlap_bad, 0);
    check({tag, " R8 read beats"}, r_cnt, NUM * LEN);
  endtask

  task automatic t_reset();
    check("R1 awvalid", int'(awvalid), 0);
    check("R1 wvalid", int'(wvalid), 0);
    check("R1 arvalid", int'(arvalid), 0);
    check("R1 bready/rready", int'(bready | rready), 0);
    check("R1 done", int'(done), 0);
    check("R1 errors", int'(err_write | err_read), 0);
  endtask

  task automatic t_clean();
    setup(1'b0, 2'b00, -1, 2'b00, -1, -1);
    pulse_start();
    wait_done("R10 clean");
    check_traffic("clean");
    for (int k = 0; k < NUM * LEN; k++)
      check("R5 memory word", int'(mem[(BASE / 4 + k) & 63]), int'(pat(k / LEN, k % LEN)));
    check("R8 no read error", int'(err_read), 0);
    check("R9 no write error", int'(err_write), 0);
    repeat (5) @(negedge clk);
    check("R10 done held", int'(done), 1);
  endtask

  task automatic t_backpressure();
    setup(1'b1, 2'b00, -1, 2'b00, -1, -1);
    pulse_start();
    check("R10 done cleared by start", int'(done), 0);
    wait_done("R3 backpressure");
    check_traffic("bp");
    check("R8 bp no error", int'(err_read | err_write), 0);
  endtask

  task automatic t_bresp_err();
    setup(1'b0, 2'b10, 1, 2'b00, -1, -1);
    pulse_start();
    wait_done("R9 bresp");
    check("R9 slverr on B sets err_write", int'(err_write), 1);
    check("R9 err_read untouched", int'(err_read), 0);
  endtask

  task automatic t_restart_clears();
    setup(1'b0, 2'b00, -1, 2'b00, -1, -1);
    pulse_start();
    check("R10 start clears err_write", int'(err_write), 0);
    wait_done("R10 restart");
    check("R10 clean after restart", int'(err_write | err_read), 0);
  endtask

  task automatic t_rresp(logic [1:0] code, int exp_err, string tag);
    setup(1'b0, 2'b00, -1, code, 2, -1);
    pulse_start();
    wait_done(tag);
    check({tag, " err_read"}, int'(err_read), exp_err);
    check({tag, " err_write"}, int'(err_write), 0);
  endtask

  task automatic t_corrupt();
    setup(1'b1, 2'b00, -1, 2'b00, -1, 1);
    pulse_start();
    wait_done("R8 corrupt");
    check("R8 mismatch sets err_read", int'(err_read), 1);
    check("R8 write side clean", int'(err_write), 0);
  endtask

  task automatic t_start_ignored();
    setup(1'b1, 2'b00, -1, 2'b00, -1, -1);
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    wait_done("R11 start ignored");
    check("R11 write bursts", aw_cnt, NUM);
    check("R11 read bursts", ar_cnt, NUM);
    check("R11 addresses", addr_bad, 0);
    check("R11 one burst at a time", overlap_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_backpressure();
    t_bresp_err();
    t_restart_clears();
    t_rresp(2'b10, 1, "R9 rresp slverr");
    t_rresp(2'b11, 1, "R9 rresp decerr");
    t_rresp(2'b01, 0, "R9 rresp exokay");
    t_corrupt();
    t_start_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule